// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers up to 32 interrupt inputs and drives two request lines toward a processor: `irq_req` for normal interrupts, which go through an eight-level nested priority scheme, and `fiq_req` for fast interrupts. Each input has its own mode word and its own vector word. The mode word holds a priority and a trigger type, which is either a level that follows the input or a latched rising edge. Input 0 is wired to the fast path. Software can also move any other input onto the fast path, which is called fast forcing.

Software uses the block over a simple word-addressed register bus. A read of the vector register is an active operation. It picks the best enabled pending input whose priority is above the level currently being serviced, returns that input's vector and pushes its priority onto an internal level stack. A write to the end-of-interrupt register pops that stack. While a higher level is in service, lower and equal levels are held back. Commands can enable, disable, set and clear inputs. A debug bit makes vector reads leave the state unchanged. A keyed write-protection switch guards the configuration registers.

Address map (word addresses on `bus_addr`): 0x00+i mode of input i (bits 2:0 priority, bit 4 = 1 for edge); 0x20+i vector of input i; 0x40 active vector read; 0x41 fast vector (input 0); 0x42 last winner id; 0x43 pending; 0x44 enable mask; 0x45 enable (write 1s); 0x46 disable; 0x47 clear latch; 0x48 set latch; 0x49 end of interrupt; 0x4A spurious vector; 0x4B debug (bit 0); 0x4C fast-force enable; 0x4D fast-force disable; 0x4E fast-force mask; 0x4F protection (bits 31:8 key 0xB10C4E, bit 0 enable); 0x50 violation status (bit 0 flag, bits 15:8 offending address, cleared by reading).

Top module: `vic_top`

## Requirements
- R1: After reset, `irq_req` and `fiq_req` are low, the enable mask, the pending word and the spurious vector read back as 0, and read data appears on `bus_rdata` one cycle after a read strobe.
- R2: Writing 1s to the enable register (0x45) unmasks those inputs and writing 1s to the disable register (0x46) masks them. A masked input never raises a request.
- R3: With mode bit 4 clear, an input is pending while it is high. With bit 4 set, a rising edge sets a latch that stays pending after the input falls.
- R4: Writing 1s to the clear register (0x47) drops those latches, and writing 1s to the set register (0x48) forces them.
- R5: A read of 0x40 returns the vector of the enabled pending normal input with the highest priority above the current level, with the lowest index winning ties. It pushes that priority, which lowers `irq_req` when nothing higher is pending.
- R6: While a level is in service, only a strictly higher priority raises `irq_req`. An end-of-interrupt write restores the previous level.
- R7: A read of 0x40 with no qualifying input returns the spurious vector (0x4A) and pushes nothing.
- R8: Input 0 drives `fiq_req` and never `irq_req`. Register 0x41 returns its vector.
- R9: An input whose fast-force bit is set drives `fiq_req` instead of `irq_req` and is invisible to the vector read. Bit 0 of the fast-force mask cannot be set.
- R10: A vector read clears the edge latch of the winner. A latched fast-path input stays pending until a clear command.
- R11: A protection write takes effect only with key 0xB10C4E. While protection is on, writes to mode, vector, spurious and debug registers are dropped and the violation flag and address are recorded.
- R12: The level stack holds eight entries. End-of-interrupt writes on an empty stack leave it empty and harmless.
- R13: With debug bit 0 set, a vector read returns the same vector but pushes no level and clears no latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | 32 | Interrupt inputs, synchronous to clk |
| bus_addr | input | 8 | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_req | output | 1 | Normal interrupt request, active high |
| fiq_req | output | 1 | Fast interrupt request, active high |

## Verification
The bench builds the block with its default parameters: 32 inputs, three priority bits and an eight-entry stack. With these values the bench can use every priority level and fill the stack completely with strictly rising levels. The 32 inputs also let the bench place equal priorities far apart, such as inputs 15 and 31, to test the lowest-index tie rule. The default key width and value let the bench test both the accepted key and a rejected one.

// File: rtl/vic_pkg.sv
package vic_pkg;

    localparam int DATA_W        = 32;
    localparam int ADDR_W        = 8;
    localparam int MODE_EDGE_BIT = 4;
    localparam int KEY_W         = 24;
    localparam logic [KEY_W-1:0] WP_KEY = 24'hB10C4E;

    typedef enum logic [4:0] {
        RS_MODE, RS_VEC, RS_IVR, RS_FVR, RS_STAT, RS_PEND, RS_MASK,
        RS_EN, RS_DIS, RS_CLR, RS_SET, RS_EOI, RS_SPU, RS_DBG,
        RS_FFEN, RS_FFDIS, RS_FFSTAT, RS_PROT, RS_PSTAT, RS_NONE
    } reg_e;

    function automatic reg_e decode(input logic [ADDR_W-1:0] a);
        if (a < 8'h20) return RS_MODE;
        if (a < 8'h40) return RS_VEC;
        case (a)
            8'h40: return RS_IVR;
            8'h41: return RS_FVR;
            8'h42: return RS_STAT;
            8'h43: return RS_PEND;
            8'h44: return RS_MASK;
            8'h45: return RS_EN;
            8'h46: return RS_DIS;
            8'h47: return RS_CLR;
            8'h48: return RS_SET;
            8'h49: return RS_EOI;
            8'h4A: return RS_SPU;
            8'h4B: return RS_DBG;
            8'h4C: return RS_FFEN;
            8'h4D: return RS_FFDIS;
            8'h4E: return RS_FFSTAT;
            8'h4F: return RS_PROT;
            8'h50: return RS_PSTAT;
            default: return RS_NONE;
        endcase
    endfunction

    function automatic logic is_guarded(input reg_e r);
        return (r == RS_MODE) || (r == RS_VEC) || (r == RS_SPU) || (r == RS_DBG);
    endfunction

endpackage

// File: rtl/vic_src_bank.sv
module vic_src_bank #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] src_in,
    input  logic [N-1:0] edge_mode,
    input  logic [N-1:0] set_cmd,
    input  logic [N-1:0] clr_cmd,
    input  logic [N-1:0] auto_clr,
    output logic [N-1:0] pending
);
    logic [N-1:0] src_q;
    logic [N-1:0] latch_q;

    always_ff @(posedge clk) begin
        if (rst) src_q <= '0;
        else     src_q <= src_in;
    end

    for (genvar i = 0; i < N; i++) begin : g_src
        logic rise;
        assign rise = src_in[i] & ~src_q[i] & edge_mode[i];
        always_ff @(posedge clk) begin
            if (rst)                          latch_q[i] <= 1'b0;
            else if (clr_cmd[i])              latch_q[i] <= 1'b0;
            else if (set_cmd[i] || rise)      latch_q[i] <= 1'b1;
            else if (auto_clr[i])             latch_q[i] <= 1'b0;
        end
        assign pending[i] = latch_q[i] | (~edge_mode[i] & src_in[i]);
    end
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter #(
    parameter int N      = 32,
    parameter int PRIO_W = 3,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]             cand,
    input  logic [N-1:0][PRIO_W-1:0] prio,
    input  logic [PRIO_W-1:0]        cur_lvl,
    input  logic                     lvl_empty,
    output logic                     win_valid,
    output logic [IDX_W-1:0]         win_id,
    output logic [PRIO_W-1:0]        win_prio
);
    logic found;

    always_comb begin
        found    = 1'b0;
        win_id   = '0;
        win_prio = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i] && (!found || prio[i] >= win_prio)) begin
                found    = 1'b1;
                win_id   = IDX_W'(i);
                win_prio = prio[i];
            end
        end
        win_valid = found && (lvl_empty || win_prio > cur_lvl);
    end
endmodule

// File: rtl/vic_level_stack.sv
module vic_level_stack #(
    parameter int DEPTH  = 8,
    parameter int PRIO_W = 3,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic              pop,
    input  logic [PRIO_W-1:0] din,
    output logic [PRIO_W-1:0] top,
    output logic              empty,
    output logic [CNT_W-1:0]  count
);
    logic [DEPTH-1:0][PRIO_W-1:0] lvl_q;
    logic [CNT_W-1:0]             cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            lvl_q <= '0;
        end else if (push) begin
            if (int'(cnt_q) < DEPTH) begin
                lvl_q[cnt_q] <= din;
                cnt_q        <= cnt_q + 1'b1;
            end
        end else if (pop && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign empty = (cnt_q == '0);
    assign count = cnt_q;
    assign top   = empty ? '0 : lvl_q[cnt_q - 1'b1];
endmodule

// File: rtl/vic_top.sv
module vic_top
    import vic_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int PRIO_W  = 3,
    parameter int DEPTH   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       src_in,
    input  logic [7:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_req,
    output logic              fiq_req
);
    localparam int IDX_W = $clog2(NUM_SRC);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [NUM_SRC-1:0] FAST_SRC = NUM_SRC'(1);

    reg_e sel;
    assign sel = decode(bus_addr);

    logic [NUM_SRC-1:0]             en_mask, ff_mask, edge_mode;
    logic [NUM_SRC-1:0][PRIO_W-1:0] src_prio;
    logic [NUM_SRC-1:0][DATA_W-1:0] src_vec;
    logic [DATA_W-1:0]              spu_vec;
    logic                           dbg_nd;
    logic                           prot_en, prot_viol;
    logic [ADDR_W-1:0]              viol_addr;
    logic [IDX_W-1:0]               cur_id;
    logic [NUM_SRC-1:0]             pending, set_cmd, clr_cmd, auto_clr;
    logic [NUM_SRC-1:0]             irq_cand, fiq_cand;
    logic                           arb_valid;
    logic [IDX_W-1:0]               arb_id;
    logic [PRIO_W-1:0]              arb_prio, cur_lvl;
    logic                           lvl_empty;
    logic [CNT_W-1:0]               stk_cnt;
    logic [IDX_W-1:0]               slot;
    logic                           slot_ok;

    // Write qualification
    logic wr_ok, wr_prot_hit, vec_rd, eoi_wr, push;
    assign wr_prot_hit = bus_wr && prot_en && is_guarded(sel);
    assign wr_ok       = bus_wr && !wr_prot_hit;
    assign vec_rd      = bus_rd && (sel == RS_IVR);
    assign eoi_wr      = wr_ok && (sel == RS_EOI);
    assign push        = vec_rd && arb_valid && !dbg_nd;
    assign slot        = bus_addr[IDX_W-1:0];
    assign slot_ok     = int'(bus_addr[4:0]) < NUM_SRC;

    assign set_cmd  = (wr_ok && sel == RS_SET) ? bus_wdata[NUM_SRC-1:0] : '0;
    assign clr_cmd  = (wr_ok && sel == RS_CLR) ? bus_wdata[NUM_SRC-1:0] : '0;
    assign auto_clr = push ? (NUM_SRC'(1) << arb_id) : '0;

    vic_src_bank #(.N(NUM_SRC)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .src_in    (src_in[NUM_SRC-1:0]),
        .edge_mode (edge_mode),
        .set_cmd   (set_cmd),
        .clr_cmd   (clr_cmd),
        .auto_clr  (auto_clr),
        .pending   (pending)
    );

    assign irq_cand = en_mask & pending & ~ff_mask & ~FAST_SRC;
    assign fiq_cand = en_mask & pending & (ff_mask | FAST_SRC);

    vic_arbiter #(.N(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
        .cand      (irq_cand),
        .prio      (src_prio),
        .cur_lvl   (cur_lvl),
        .lvl_empty (lvl_empty),
        .win_valid (arb_valid),
        .win_id    (arb_id),
        .win_prio  (arb_prio)
    );

    vic_level_stack #(.DEPTH(DEPTH), .PRIO_W(PRIO_W)) u_stack (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .pop   (eoi_wr),
        .din   (arb_prio),
        .top   (cur_lvl),
        .empty (lvl_empty),
        .count (stk_cnt)
    );

    assign irq_req = arb_valid;
    assign fiq_req = |fiq_cand;

    // Configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            en_mask   <= '0;
            ff_mask   <= '0;
            edge_mode <= '0;
            src_prio  <= '0;
            src_vec   <= '0;
            spu_vec   <= '0;
            dbg_nd    <= 1'b0;
            prot_en   <= 1'b0;
            cur_id    <= '0;
        end else begin
            if (wr_ok) begin
                case (sel)
                    RS_MODE: if (slot_ok) begin
                        src_prio[slot]  <= bus_wdata[PRIO_W-1:0];
                        edge_mode[slot] <= bus_wdata[MODE_EDGE_BIT];
                    end
                    RS_VEC:   if (slot_ok) src_vec[slot] <= bus_wdata;
                    RS_EN:    en_mask <= en_mask | bus_wdata[NUM_SRC-1:0];
                    RS_DIS:   en_mask <= en_mask & ~bus_wdata[NUM_SRC-1:0];
                    RS_SPU:   spu_vec <= bus_wdata;
                    RS_DBG:   dbg_nd  <= bus_wdata[0];
                    RS_FFEN:  ff_mask <= (ff_mask | bus_wdata[NUM_SRC-1:0]) & ~FAST_SRC;
                    RS_FFDIS: ff_mask <= ff_mask & ~bus_wdata[NUM_SRC-1:0];
                    RS_PROT:  if (bus_wdata[31:8] == WP_KEY) prot_en <= bus_wdata[0];
                    default: ;
                endcase
            end
            if (push) cur_id <= arb_id;
        end
    end

    // Violation record
    always_ff @(posedge clk) begin
        if (rst) begin
            prot_viol <= 1'b0;
            viol_addr <= '0;
        end else if (wr_prot_hit) begin
            prot_viol <= 1'b1;
            viol_addr <= bus_addr;
        end else if (bus_rd && sel == RS_PSTAT) begin
            prot_viol <= 1'b0;
            viol_addr <= '0;
        end
    end

    // Registered read data
    logic [DATA_W-1:0] rd_mux;
    always_comb begin
        rd_mux = '0;
        case (sel)
            RS_MODE: if (slot_ok) begin
                rd_mux[PRIO_W-1:0]    = src_prio[slot];
                rd_mux[MODE_EDGE_BIT] = edge_mode[slot];
            end
            RS_VEC:    if (slot_ok) rd_mux = src_vec[slot];
            RS_IVR:    rd_mux = arb_valid ? src_vec[arb_id] : spu_vec;
            RS_FVR:    rd_mux = src_vec[0];
            RS_STAT:   rd_mux = DATA_W'(cur_id);
            RS_PEND:   rd_mux = DATA_W'(pending);
            RS_MASK:   rd_mux = DATA_W'(en_mask);
            RS_SPU:    rd_mux = spu_vec;
            RS_DBG:    rd_mux = DATA_W'(dbg_nd);
            RS_FFSTAT: rd_mux = DATA_W'(ff_mask);
            RS_PROT:   rd_mux = DATA_W'(prot_en);
            RS_PSTAT:  rd_mux = {16'b0, viol_addr, 7'b0, prot_viol};
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end
endmodule

// File: rtl/vic_checker.sv
module vic_checker #(
    parameter int IDX_W = 5,
    parameter int CNT_W = 4,
    parameter int DEPTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             vec_rd,
    input logic             eoi_wr,
    input logic             arb_valid,
    input logic [IDX_W-1:0] arb_id,
    input logic             dbg_nd,
    input logic [CNT_W-1:0] stk_cnt,
    input logic             wr_prot_hit,
    input logic             prot_viol
);
    AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (rst)
        int'(stk_cnt) <= DEPTH);                                             // R12
    AST_OVERPOP_SAFE: assert property (@(posedge clk) disable iff (rst)
        (eoi_wr && !vec_rd && stk_cnt == '0) |=> stk_cnt == '0);             // R12
    AST_PUSH_ON_READ: assert property (@(posedge clk) disable iff (rst)
        (vec_rd && arb_valid && !dbg_nd && int'(stk_cnt) < DEPTH)
        |=> stk_cnt == CNT_W'($past(stk_cnt) + 1'b1));                       // R5
    AST_DEBUG_NO_PUSH: assert property (@(posedge clk) disable iff (rst)
        (vec_rd && dbg_nd && !eoi_wr) |=> $stable(stk_cnt));                 // R13
    AST_SRC0_NOT_IRQ: assert property (@(posedge clk) disable iff (rst)
        arb_valid |-> arb_id != '0);                                         // R8
    AST_PROT_FLAG: assert property (@(posedge clk) disable iff (rst)
        wr_prot_hit |=> prot_viol);                                          // R11
endmodule

bind vic_top vic_checker #(.IDX_W(IDX_W), .CNT_W(CNT_W), .DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .vec_rd      (vec_rd),
    .eoi_wr      (eoi_wr),
    .arb_valid   (arb_valid),
    .arb_id      (arb_id),
    .dbg_nd      (dbg_nd),
    .stk_cnt     (stk_cnt),
    .wr_prot_hit (wr_prot_hit),
    .prot_viol   (prot_viol)
);

// File: tb/vic_top_test.sv
`timescale 1ns/1ps
module vic_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src_in = '0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_req, fiq_req;

    int n_chk = 0, n_fail = 0;
    logic [31:0] rv;
    localparam logic [31:0] SPU = 32'h0000_DEAD;

    always #4 clk = ~clk;

    vic_top uut (.*);

    // {source pattern, expected vector}; priorities are index % 8, vectors 0x100 + index
    localparam logic [63:0] TBL [8] = '{
        {32'h0000_0002, 32'h0000_0101},
        {32'h0000_0006, 32'h0000_0102},
        {32'h0000_0108, 32'h0000_0103},
        {32'h0000_0880, 32'h0000_0107},
        {32'h8000_8000, 32'h0000_010F},
        {32'h0000_0000, SPU},
        {32'h0000_0201, 32'h0000_0109},
        {32'h0001_0100, 32'h0000_0108}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
    endtask

    task automatic pulse(input int s);
        @(negedge clk); src_in[s] = 1'b1;
        @(negedge clk); src_in[s] = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk); #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        settle();
        chk("R1 irq", {31'b0, irq_req}, 0);
        chk("R1 fiq", {31'b0, fiq_req}, 0);
        rd(8'h43, rv); chk("R1 pending", rv, 0);
        rd(8'h44, rv); chk("R1 mask", rv, 0);
        rd(8'h40, rv); chk("R1 spurious", rv, 0);

        for (int i = 0; i < 32; i++) begin
            wr(8'(i), 32'(i % 8));
            wr(8'(8'h20 + i), 32'h100 + 32'(i));
        end
        wr(8'h4A, SPU);
        wr(8'h45, 32'hFFFF_FFFF);

        // R5 R7 table walk
        for (int k = 0; k < 8; k++) begin
            @(negedge clk); src_in = TBL[k][63:32];
            settle();
            chk("R5 irq before read", {31'b0, irq_req}, {31'b0, |(TBL[k][63:33])});
            rd(8'h40, rv);
            chk(TBL[k][31:0] == SPU ? "R7 spurious" : "R5 vector", rv, TBL[k][31:0]);
            wr(8'h49, 0);
        end
        @(negedge clk); src_in = '0;

        // R2 masking
        wr(8'h46, 32'h20);
        @(negedge clk); src_in = 32'h20;
        settle(); chk("R2 masked", {31'b0, irq_req}, 0);
        rd(8'h44, rv); chk("R2 mask readback", rv, 32'hFFFF_FFDF);
        wr(8'h45, 32'h20);
        settle(); chk("R2 unmasked", {31'b0, irq_req}, 1);
        @(negedge clk); src_in = '0;
        settle(); chk("R3 level drop", {31'b0, irq_req}, 0);

        // R6 nesting
        @(negedge clk); src_in = 32'h4;
        rd(8'h40, rv); chk("R6 first", rv, 32'h102);
        settle(); chk("R6 in service", {31'b0, irq_req}, 0);
        @(negedge clk); src_in = 32'h44;
        settle(); chk("R6 higher preempts", {31'b0, irq_req}, 1);
        rd(8'h40, rv); chk("R6 nested", rv, 32'h106);
        rd(8'h42, rv); chk("R6 id", rv, 6);
        @(negedge clk); src_in = 32'h4;
        wr(8'h49, 0);
        settle(); chk("R6 back to lvl2", {31'b0, irq_req}, 0);
        wr(8'h49, 0);
        settle(); chk("R6 restored", {31'b0, irq_req}, 1);
        @(negedge clk); src_in = '0;

        // R13 debug
        wr(8'h4B, 1);
        @(negedge clk); src_in = 32'h8;
        rd(8'h40, rv); chk("R13 read1", rv, 32'h103);
        rd(8'h40, rv); chk("R13 read2", rv, 32'h103);
        settle(); chk("R13 no push", {31'b0, irq_req}, 1);
        wr(8'h4B, 0);
        rd(8'h40, rv); chk("R13 normal read", rv, 32'h103);
        settle(); chk("R13 pushed", {31'b0, irq_req}, 0);
        wr(8'h49, 0);
        @(negedge clk); src_in = '0;

        // R12 full stack and over-pop
        begin
            int ids [8] = '{8, 1, 2, 3, 12, 5, 6, 7};
            for (int k = 0; k < 8; k++) begin
                @(negedge clk); src_in[ids[k]] = 1'b1;
                rd(8'h40, rv); chk("R12 fill", rv, 32'h100 + 32'(ids[k]));
            end
        end
        settle(); chk("R12 full", {31'b0, irq_req}, 0);
        @(negedge clk); src_in = 32'h2;
        for (int k = 0; k < 6; k++) wr(8'h49, 0);
        settle(); chk("R12 level1", {31'b0, irq_req}, 0);
        wr(8'h49, 0);
        settle(); chk("R12 level0", {31'b0, irq_req}, 1);
        for (int k = 0; k < 4; k++) wr(8'h49, 0);
        rd(8'h40, rv); chk("R12 after overpop", rv, 32'h101);
        settle(); chk("R12 push ok", {31'b0, irq_req}, 0);
        wr(8'h49, 0);
        @(negedge clk); src_in = '0;

        // R3 R4 R10 edge latch
        wr(8'h04, 32'h14);
        pulse(4);
        rd(8'h43, rv); chk("R3 edge latched", rv, 32'h10);
        settle(); chk("R3 edge irq", {31'b0, irq_req}, 1);
        wr(8'h47, 32'h10);
        rd(8'h43, rv); chk("R4 clear", rv, 0);
        wr(8'h48, 32'h10);
        rd(8'h43, rv); chk("R4 set", rv, 32'h10);
        rd(8'h40, rv); chk("R10 edge vector", rv, 32'h104);
        rd(8'h43, rv); chk("R10 auto clear", rv, 0);
        wr(8'h49, 0);

        // R8 fast source
        @(negedge clk); src_in = 32'h1;
        settle(); chk("R8 fiq", {31'b0, fiq_req}, 1);
        chk("R8 no irq", {31'b0, irq_req}, 0);
        rd(8'h41, rv); chk("R8 fast vector", rv, 32'h100);
        @(negedge clk); src_in = '0;
        settle(); chk("R8 fiq drop", {31'b0, fiq_req}, 0);

        // R9 R10 fast forcing
        wr(8'h0A, 32'h12);
        wr(8'h4C, 32'h0000_0401);
        rd(8'h4E, rv); chk("R9 ff mask", rv, 32'h400);
        pulse(10);
        settle(); chk("R9 fiq", {31'b0, fiq_req}, 1);
        chk("R9 no irq", {31'b0, irq_req}, 0);
        rd(8'h40, rv); chk("R9 hidden", rv, SPU);
        settle(); chk("R10 fast not auto cleared", {31'b0, fiq_req}, 1);
        wr(8'h47, 32'h400);
        settle(); chk("R10 fast cleared", {31'b0, fiq_req}, 0);
        wr(8'h4D, 32'h400);

        // R11 protection
        wr(8'h4F, 32'h1234_5601);
        rd(8'h4F, rv); chk("R11 bad key", rv, 0);
        wr(8'h4F, 32'hB10C_4E01);
        rd(8'h4F, rv); chk("R11 good key", rv, 1);
        wr(8'h21, 32'h999);
        rd(8'h50, rv); chk("R11 violation", rv, 32'h2101);
        rd(8'h50, rv); chk("R11 cleared", rv, 0);
        @(negedge clk); src_in = 32'h2;
        rd(8'h40, rv); chk("R11 vector kept", rv, 32'h101);
        wr(8'h49, 0);
        @(negedge clk); src_in = '0;
        wr(8'h4F, 32'hB10C_4E00);
        rd(8'h4F, rv); chk("R11 unlock", rv, 0);

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule